// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits between a shared interrupt source controller and one processor. It keeps the processor's interrupt state in three pieces: a 32-bit pending word, the priority of whatever is pending, and an inter-processor-interrupt (IPI) priority. The pending word has the processor's current priority in its top byte and the number of the pending source in its low 24 bits. A source field of zero means nothing is pending. Smaller priority values win, and 0xFF is the least favored value. It also stands for "nothing pending".

The source controller offers interrupts as (source number, priority) pairs. The block either takes the offer or refuses it on the reject channel. When it takes an offer that displaces an older pending source interrupt, it rejects the older one instead. The processor works through a register port. Accept reads the pending word and acknowledges it. Poll reads it with no side effects. The port also offers a write of the current priority, a write of the IPI priority, and end-of-interrupt. When the block becomes less restrictive it asks the source controller to resend, and it forwards end-of-interrupt source numbers to the source controller. All notifications are one-cycle strobes that appear in the cycle after the operation that caused them.

Top module: `intr_presenter`

## Requirements
- R1: After reset the pending word reads 0x00000000, the pending priority and the IPI priority are 0xFF, the interrupt output is low and no strobe is active.
- R2: An offer with priority P is refused if P is greater than or equal to the current priority, or if a source is pending with pending priority less than or equal to P. A refusal pulses the reject strobe with the offered number and leaves the state unchanged.
- R3: A taken offer rejects any pending interrupt that a source owns. It then loads the offered number into bits 23:0, records P as the pending priority and raises the output.
- R4: An IPI priority write with a value M below the current priority does nothing more if a pending interrupt has priority less than or equal to M. Otherwise it rejects any source-owned pending interrupt, loads source number 2 with pending priority M, and raises the output. A write of M greater than or equal to the current priority only stores M.
- R5: An interrupt loaded through the IPI path (number 2) is never reported on the reject strobe when it is displaced or dropped.
- R6: Accept (opcode 0) returns the old pending word one cycle later and lowers the output. It leaves the pending word equal to {old pending priority, 24'h0} and sets the pending priority to 0xFF.
- R7: A current-priority write (opcode 2, value in bits 7:0) that is more favored than the current priority, while a pending interrupt has priority greater than or equal to the new value, clears the source field, sets the pending priority to 0xFF, lowers the output and rejects a source-owned number.
- R8: A current-priority write that is not more favored, while nothing is pending, pulses the resend strobe. If the IPI priority is below the new current priority, it also loads the IPI as in R4.
- R9: End-of-interrupt (opcode 4) copies bits 31:24 of the written data into the current priority and pulses the EOI strobe with bits 23:0. If nothing is pending afterwards, it performs the resend of R8.
- R10: Poll (opcode 1) returns the pending word one cycle later and changes no state.
- R11: The interrupt output is high exactly when the source field is nonzero, and the pending priority is 0xFF exactly when the source field is zero.
- R12: A register operation has priority over an offer in the same cycle. The ready output is low while an operation is presented, and an offer made then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Offer from the source controller |
| reqSrc | input | 24 | Offered source number (nonzero, not 2) |
| reqPrio | input | 8 | Offered priority |
| reqReady | output | 1 | Offer is considered this cycle |
| opValid | input | 1 | Register operation strobe |
| opCode | input | 3 | 0 accept, 1 poll, 2 write current priority, 3 write IPI priority, 4 end-of-interrupt |
| opData | input | 32 | Write data for operations 2, 3 and 4 |
| rdValid | output | 1 | Read data valid (accept, poll) |
| rdData | output | 32 | Pending word returned |
| irqOut | output | 1 | Interrupt line to the processor |
| rejValid | output | 1 | Reject strobe to the source controller |
| rejSrc | output | 24 | Rejected source number |
| eoiValid | output | 1 | End-of-interrupt strobe to the source controller |
| eoiSrc | output | 24 | Source number being ended |
| resendValid | output | 1 | Resend request to the source controller |

## Verification
On every cycle the assertions check that the output line follows the source field and that the pending priority shows idleness. They also check the refusal rule, what accept, poll and end-of-interrupt leave behind, that an IPI write at or above the current priority changes nothing, and that a reject not caused by an offer always comes from a source-owned slot. Only the bench's scenarios show the full arbitration sequences: displacement chains, the resend path that reloads the IPI, drops caused by a current-priority write, and the ordering of operations against offers in the same cycle. A behavioural model checks all of these through a long random mix of operations and offers.

// File: rtl/presenter_pkg.sv
package presenter_pkg;
  localparam int unsigned SRC_W  = 24;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned WORD_W = SRC_W + PRIO_W;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ACCEPT  = 3'd0,
    OP_POLL    = 3'd1,
    OP_SETCPPR = 3'd2,
    OP_SETIPI  = 3'd3,
    OP_EOI     = 3'd4
  } opKind_e;

  typedef struct packed {
    logic              ldCppr;
    logic [PRIO_W-1:0] cpprVal;
    logic              dropSrc;
    logic              takeReq;
    logic              takeIpi;
    logic [PRIO_W-1:0] ipiPrio;
    logic              ldMfrr;
    logic [PRIO_W-1:0] mfrrVal;
    logic              rejFire;
    logic [SRC_W-1:0]  rejNum;
    logic              eoiFire;
    logic [SRC_W-1:0]  eoiNum;
    logic              resendFire;
    logic              readOut;
  } ctrlStb_t;
endpackage

// File: rtl/presenter_ctrl.sv
module presenter_ctrl
  import presenter_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [WORD_W-1:0] opData,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [PRIO_W-1:0] curCppr,
  input  logic [SRC_W-1:0]  curSrc,
  input  logic [PRIO_W-1:0] curPend,
  input  logic [PRIO_W-1:0] curMfrr,
  input  logic              curOwned,
  output logic              reqReady,
  output ctrlStb_t          stb
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic              srcPending;
  logic [PRIO_W-1:0] wrPrio;
  logic [PRIO_W-1:0] eoiPrio;

  assign srcPending = (curSrc != '0);
  assign wrPrio     = opData[PRIO_W-1:0];
  assign eoiPrio    = opData[WORD_W-1:SRC_W];
  assign reqReady   = !opValid;

  always_comb begin
    stb = '0;
    if (opValid) begin
      unique case (opKind_e'(opCode))
        OP_ACCEPT: begin
          stb.readOut = 1'b1;
          stb.ldCppr  = 1'b1;
          stb.cpprVal = curPend;
          stb.dropSrc = 1'b1;
        end
        OP_POLL: begin
          stb.readOut = 1'b1;
        end
        OP_SETCPPR: begin
          stb.ldCppr  = 1'b1;
          stb.cpprVal = wrPrio;
          if (wrPrio < curCppr) begin
            if (srcPending && (wrPrio <= curPend)) begin
              stb.dropSrc = 1'b1;
              if (curOwned) begin
                stb.rejFire = 1'b1;
                stb.rejNum  = curSrc;
              end
            end
          end else if (!srcPending) begin
            stb.resendFire = 1'b1;
            if (curMfrr < wrPrio) begin
              stb.takeIpi = 1'b1;
              stb.ipiPrio = curMfrr;
            end
          end
        end
        OP_SETIPI: begin
          stb.ldMfrr  = 1'b1;
          stb.mfrrVal = wrPrio;
          if ((wrPrio < curCppr) && !(srcPending && (curPend <= wrPrio))) begin
            stb.takeIpi = 1'b1;
            stb.ipiPrio = wrPrio;
            if (srcPending && curOwned) begin
              stb.rejFire = 1'b1;
              stb.rejNum  = curSrc;
            end
          end
        end
        OP_EOI: begin
          stb.ldCppr  = 1'b1;
          stb.cpprVal = eoiPrio;
          stb.eoiFire = 1'b1;
          stb.eoiNum  = opData[SRC_W-1:0];
          if (!srcPending) begin
            stb.resendFire = 1'b1;
            if (curMfrr < eoiPrio) begin
              stb.takeIpi = 1'b1;
              stb.ipiPrio = curMfrr;
            end
          end
        end
        default: ;
      endcase
    end else if (reqValid) begin
      if ((reqPrio >= curCppr) || (srcPending && (curPend <= reqPrio))) begin
        stb.rejFire = 1'b1;
        stb.rejNum  = reqSrc;
      end else begin
        stb.takeReq = 1'b1;
        if (srcPending && curOwned) begin
          stb.rejFire = 1'b1;
          stb.rejNum  = curSrc;
        end
      end
    end
  end

  // R3: at most one kind of change to the pending slot per cycle
  p_one_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.takeReq, stb.takeIpi, stb.dropSrc}));

  // R5: an IPI pending slot never yields a reject of its number
  p_ipi_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rejFire && !stb.takeReq && !(reqValid && reqReady && stb.rejNum == reqSrc))
      |-> curOwned);

  logic unusedPrio;
  assign unusedPrio = (PRIO_NONE == '0);
endmodule

// File: rtl/presenter_dp.sv
module presenter_dp
  import presenter_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  output logic [PRIO_W-1:0] curCppr,
  output logic [SRC_W-1:0]  curSrc,
  output logic [PRIO_W-1:0] curPend,
  output logic [PRIO_W-1:0] curMfrr,
  output logic              curOwned,
  output logic              irqOut,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendValid
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCppr  <= '0;
      curSrc   <= '0;
      curPend  <= PRIO_NONE;
      curMfrr  <= PRIO_NONE;
      curOwned <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      if (stb.ldCppr) curCppr <= stb.cpprVal;
      if (stb.ldMfrr) curMfrr <= stb.mfrrVal;
      if (stb.dropSrc) begin
        curSrc   <= '0;
        curPend  <= PRIO_NONE;
        curOwned <= 1'b0;
        irqOut   <= 1'b0;
      end else if (stb.takeReq) begin
        curSrc   <= reqSrc;
        curPend  <= reqPrio;
        curOwned <= 1'b1;
        irqOut   <= 1'b1;
      end else if (stb.takeIpi) begin
        curSrc   <= IPI_SRC;
        curPend  <= stb.ipiPrio;
        curOwned <= 1'b0;
        irqOut   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid     <= 1'b0;
      rdData      <= '0;
      rejValid    <= 1'b0;
      rejSrc      <= '0;
      eoiValid    <= 1'b0;
      eoiSrc      <= '0;
      resendValid <= 1'b0;
    end else begin
      rdValid     <= stb.readOut;
      rejValid    <= stb.rejFire;
      eoiValid    <= stb.eoiFire;
      resendValid <= stb.resendFire;
      if (stb.readOut) rdData <= {curCppr, curSrc};
      if (stb.rejFire) rejSrc <= stb.rejNum;
      if (stb.eoiFire) eoiSrc <= stb.eoiNum;
    end
  end

  // R11: output line follows the source field; idle priority follows it too
  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (curSrc != '0));
  p_pend_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (curSrc == '0) == (curPend == PRIO_NONE));
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import presenter_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  output logic              reqReady,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [WORD_W-1:0] opData,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendValid
);
  ctrlStb_t          stb;
  logic [PRIO_W-1:0] curCppr;
  logic [SRC_W-1:0]  curSrc;
  logic [PRIO_W-1:0] curPend;
  logic [PRIO_W-1:0] curMfrr;
  logic              curOwned;

  presenter_ctrl #(.IPI_SRC(IPI_SRC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .opValid(opValid), .opCode(opCode), .opData(opData),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqPrio(reqPrio),
    .curCppr(curCppr), .curSrc(curSrc), .curPend(curPend),
    .curMfrr(curMfrr), .curOwned(curOwned),
    .reqReady(reqReady), .stb(stb)
  );

  presenter_dp #(.IPI_SRC(IPI_SRC)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqSrc(reqSrc), .reqPrio(reqPrio),
    .curCppr(curCppr), .curSrc(curSrc), .curPend(curPend),
    .curMfrr(curMfrr), .curOwned(curOwned), .irqOut(irqOut),
    .rdValid(rdValid), .rdData(rdData),
    .rejValid(rejValid), .rejSrc(rejSrc),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendValid(resendValid)
  );

  // R2: a refused offer is bounced with its own number and changes nothing
  p_refuse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqPrio >= curCppr))
      |=> rejValid && (rejSrc == $past(reqSrc)) && $stable(curSrc) && $stable(curPend));

  // R4: an IPI write at or above the current priority only stores the value
  p_ipi_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SETIPI && (opData[PRIO_W-1:0] >= curCppr))
      |=> $stable(curSrc) && !rejValid && (curMfrr == $past(opData[PRIO_W-1:0])));

  // R5: a reject not caused by an offer comes from a source-owned slot
  p_rej_owned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rejValid && !$past(reqValid && reqReady)) |-> $past(curOwned));

  // R6: accept returns the old word and leaves only the old pending priority
  p_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ACCEPT)
      |=> rdValid && (rdData == $past({curCppr, curSrc})) && !irqOut
          && (curCppr == $past(curPend)) && (curSrc == '0));

  // R9: end-of-interrupt forwards the number and loads the current priority
  p_eoi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_EOI)
      |=> eoiValid && (eoiSrc == $past(opData[SRC_W-1:0]))
          && (curCppr == $past(opData[WORD_W-1:SRC_W])));

  // R10: poll changes no state
  p_poll_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_POLL)
      |=> rdValid && $stable(curSrc) && $stable(curCppr) && $stable(curPend)
          && $stable(curMfrr) && !rejValid && !resendValid);
endmodule

// File: tb/tb_intr_presenter.sv
module tb_intr_presenter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqSrc = '0;
  logic [7:0]  reqPrio = '0;
  logic        reqReady;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] opData = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        irqOut;
  logic        rejValid;
  logic [23:0] rejSrc;
  logic        eoiValid;
  logic [23:0] eoiSrc;
  logic        resendValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_presenter dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqPrio(reqPrio), .reqReady(reqReady),
    .opValid(opValid), .opCode(opCode), .opData(opData),
    .rdValid(rdValid), .rdData(rdData), .irqOut(irqOut),
    .rejValid(rejValid), .rejSrc(rejSrc),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendValid(resendValid)
  );

  int tests = 0;
  int fails = 0;
  string curTag = "R1";
  string mTag = "R1";

  // behavioural reference state
  logic [7:0]  mCppr = 8'h00;
  logic [23:0] mSrc = '0;
  logic [7:0]  mPend = 8'hFF;
  logic [7:0]  mMfrr = 8'hFF;
  bit          mOwned = 0;
  bit          eRd = 0, eRej = 0, eEoi = 0, eResend = 0;
  logic [31:0] eRdD = '0;
  logic [23:0] eRejN = '0, eEoiN = '0;

  task automatic reject(input logic [23:0] n);
    eRej = 1; eRejN = n;
  endtask

  task automatic resendPath();
    eResend = 1;
    if (mMfrr < mCppr) begin
      mSrc = 24'd2; mPend = mMfrr; mOwned = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCppr = 0; mSrc = 0; mPend = 8'hFF; mMfrr = 8'hFF; mOwned = 0;
      eRd = 0; eRej = 0; eEoi = 0; eResend = 0;
    end else begin
      eRd = 0; eRej = 0; eEoi = 0; eResend = 0;
      mTag = curTag;
      if (opValid) begin
        case (opCode)
          3'd0: begin
            eRd = 1; eRdD = {mCppr, mSrc};
            mCppr = mPend; mSrc = 0; mPend = 8'hFF; mOwned = 0;
          end
          3'd1: begin eRd = 1; eRdD = {mCppr, mSrc}; end
          3'd2: begin
            logic [7:0] old;
            old = mCppr; mCppr = opData[7:0];
            if (mCppr < old) begin
              if (mSrc != 0 && mCppr <= mPend) begin
                if (mOwned) reject(mSrc);
                mSrc = 0; mPend = 8'hFF; mOwned = 0;
              end
            end else if (mSrc == 0) resendPath();
          end
          3'd3: begin
            mMfrr = opData[7:0];
            if (mMfrr < mCppr && !(mSrc != 0 && mPend <= mMfrr)) begin
              if (mSrc != 0 && mOwned) reject(mSrc);
              mSrc = 24'd2; mPend = mMfrr; mOwned = 0;
            end
          end
          3'd4: begin
            mCppr = opData[31:24];
            eEoi = 1; eEoiN = opData[23:0];
            if (mSrc == 0) resendPath();
          end
          default: ;
        endcase
      end else if (reqValid) begin
        if (reqPrio >= mCppr || (mSrc != 0 && mPend <= reqPrio)) reject(reqSrc);
        else begin
          if (mSrc != 0 && mOwned) reject(mSrc);
          mSrc = reqSrc; mPend = reqPrio; mOwned = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", mTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(irqOut == (mSrc != 0), "irqOut (R11)", {31'b0, irqOut}, {31'b0, mSrc != 0});
      check(rejValid == eRej && (!eRej || rejSrc == eRejN), "reject strobe",
            {rejValid, 7'b0, rejSrc}, {eRej, 7'b0, eRejN});
      check(eoiValid == eEoi && (!eEoi || eoiSrc == eEoiN), "eoi strobe",
            {eoiValid, 7'b0, eoiSrc}, {eEoi, 7'b0, eEoiN});
      check(resendValid == eResend, "resend strobe", {31'b0, resendValid}, {31'b0, eResend});
      check(rdValid == eRd && (!eRd || rdData == eRdD), "read data",
            eRd ? rdData : {31'b0, rdValid}, eRd ? eRdD : 32'b0);
    end
  end

  task automatic doOp(input logic [2:0] c, input logic [31:0] d, input string tag);
    @(negedge clk);
    curTag = tag; opValid = 1; opCode = c; opData = d;
    @(posedge clk); #1;
    opValid = 0;
  endtask

  task automatic doReq(input logic [23:0] s, input logic [7:0] p, input string tag);
    @(negedge clk);
    curTag = tag; reqValid = 1; reqSrc = s; reqPrio = p;
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic expectWord(input logic [31:0] w, input string tag);
    doOp(3'd1, 0, tag);
    @(negedge clk); #1;
    tests++;
    if (!(rdValid && rdData == w)) begin
      fails++;
      $display("FAIL %s poll word actual=%h expected=%h", tag, rdData, w);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    @(negedge clk);
    tests++;
    if (irqOut || rejValid || eoiValid || resendValid || rdValid) begin
      fails++;
      $display("FAIL R1 outputs after reset actual=%b expected=0",
               {irqOut, rejValid, eoiValid, resendValid, rdValid});
    end
    expectWord(32'h0000_0000, "R1");
    // R2 nothing taken while current priority is 0
    doReq(24'h123, 8'h05, "R2");
    doOp(3'd2, 32'hFF, "R8");              // not more favored, idle: resend
    doReq(24'h100, 8'h05, "R3");
    doReq(24'h200, 8'h05, "R2");           // equal to pending: refused
    doReq(24'h201, 8'hFF, "R2");           // not below current: refused
    doReq(24'h300, 8'h03, "R3");           // displaces 0x100
    expectWord(32'hFF00_0300, "R10");
    doOp(3'd0, 0, "R6");
    expectWord(32'h0300_0000, "R6");
    doOp(3'd4, 32'hFF00_0300, "R9");
    doOp(3'd3, 32'h10, "R4");              // IPI loaded
    expectWord(32'hFF00_0002, "R4");
    doReq(24'h400, 8'h04, "R5");           // displaces IPI silently
    doOp(3'd3, 32'h08, "R4");              // pending more favored: nothing
    doOp(3'd3, 32'h02, "R4");              // rejects 0x400, IPI at 2
    doOp(3'd2, 32'h01, "R5");              // drops IPI, no reject
    doReq(24'h500, 8'h00, "R3");
    doOp(3'd2, 32'h00, "R7");              // hmm 0 < 1, drops 0x500 with reject
    doOp(3'd2, 32'h80, "R8");              // resend plus IPI reload
    expectWord(32'h8000_0002, "R8");
    doOp(3'd4, 32'h4000_0077, "R9");       // pending: no resend
    // R12 operation beats offer
    @(negedge clk);
    curTag = "R12"; opValid = 1; opCode = 3'd1; reqValid = 1; reqSrc = 24'h600; reqPrio = 8'h00;
    #1;
    tests++;
    if (reqReady) begin
      fails++;
      $display("FAIL R12 reqReady actual=1 expected=0");
    end
    @(posedge clk); #1;
    opValid = 0; reqValid = 0;
    expectWord(32'h4000_0002, "R12");
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int sel;
      @(negedge clk);
      curTag = "R2 R3 R4 R6 R7 R8 R9 random";
      sel = $urandom % 10;
      opValid = (sel < 5) || (sel == 9);
      reqValid = (sel >= 5);
      opCode = 3'($urandom % 5);
      opData = {(($urandom % 6) == 0) ? 8'hFF : 8'($urandom % 16),
                24'h10 + 24'($urandom % 8)};
      if (opCode == 3'd2 || opCode == 3'd3)
        opData[7:0] = (($urandom % 6) == 0) ? 8'hFF : 8'($urandom % 16);
      reqSrc = 24'h10 + 24'($urandom % 8);
      reqPrio = 8'($urandom % 16);
      @(posedge clk); #1;
      opValid = 0; reqValid = 0;
    end
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule